// File: doc/BRIEF.md
# Carry-Save Tree Multiplier

This block multiplies two unsigned operands, `a` (N bits) and `b` (M bits), and returns their full (N+M)-bit product. It first forms one partial-product row for every bit of `b`: the row is `a` gated by that bit and shifted left by its position. It then reduces these M rows with levels of 3:2 counters. Each counter level takes every group of three rows and turns it into two rows, a sum row and a carry row. The carry row moves one column left. Rows left over from the grouping pass straight through to the next level. Because a counter level never propagates a carry along a row, the delay of each level is one full adder, whatever the operand width. Reduction continues until two rows remain, and one carry-propagate adder then adds them.

The number of counter levels grows as log base 1.5 of M. For the default M = 8 the row count goes 8, 6, 4, 3, 2, which gives four levels. The parameter `PIPE_MASK` decides where pipeline registers go. Bit k, for k below the level count, places a register after counter level k. The bit whose index equals the level count places a register after the final adder. A valid flag moves through the same registers as the data, so it stays aligned with its product. With the mask set to zero the block is purely combinational.

Top module: `wt_mult`

## Requirements
- R1: `product` equals the unsigned product `a*b` of the operands presented with `in_valid` high, and appears LAT clock cycles after they are presented.
- R2: `out_valid` repeats `in_valid` delayed by exactly LAT cycles, in step with the product it qualifies.
- R3: LAT is the number of set bits of `PIPE_MASK` among positions 0 to LEVELS. LEVELS is the number of 3:2 levels needed to bring M rows down to two. For N = M = 8 and `PIPE_MASK` = 0x15, LEVELS is 4 and LAT is 3.
- R4: While `rst_n` is low, and after it is released until the first valid operands have crossed the pipeline, `out_valid` is 0. This holds also when reset is applied in the middle of a stream.
- R5: A zero in either operand gives a product of zero.
- R6: All-ones operands give the largest product (2^N-1)(2^M-1), which is 0xFE01 for 8x8.
- R7: A new operand pair is accepted on every clock cycle. Back-to-back operands each yield their own correct product with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Active-low reset; clears the pipeline registers |
| in_valid | input | 1 | Marks `a` and `b` as a pair to multiply |
| a | input | N | Multiplicand, unsigned |
| b | input | M | Multiplier, unsigned; one partial-product row per bit |
| out_valid | output | 1 | Marks `product` as the result of a valid pair |
| product | output | N+M | Unsigned product |

## Verification
A table of fixed operand pairs is streamed back to back. The table holds single bits in the top and bottom positions, alternating bit patterns, nibble-complementary values and all-ones operands. These bring out faulty carry routing into the next column and faulty handling of the leftover rows in a level. Zero operands separate a correct partial-product gate from a stuck one. All-ones operands put the most carries into the highest columns. In a long random run `in_valid` is toggled at random, which shows whether the valid flag stays aligned with the data and whether results leak out in cycles without a valid pair. A reset in the middle of the stream checks that every in-flight flag is cleared.

// File: rtl/wt_pkg.sv
package wt_pkg;

    // Number of rows left after one level of 3:2 counters.
    function automatic int rows_next(input int r);
        if (r < 3) return r;
        return 2 * (r / 3) + (r % 3);
    endfunction

    // Number of rows left after k levels.
    function automatic int rows_after(input int r, input int k);
        int x;
        x = r;
        for (int i = 0; i < k; i++) x = rows_next(x);
        return x;
    endfunction

    // Number of levels needed to bring r rows down to at most two.
    function automatic int tree_levels(input int r);
        int x;
        int n;
        x = r;
        n = 0;
        while (x > 2) begin
            x = rows_next(x);
            n++;
        end
        return n;
    endfunction

    // Number of register stages: set mask bits at positions 0 to lv.
    function automatic int stage_count(input int lv, input logic [31:0] mask);
        int c;
        c = 0;
        for (int i = 0; i <= lv; i++) if (mask[i]) c++;
        return c;
    endfunction

endpackage

// File: rtl/wt_counter32.sv
// Row-wide 3:2 counter: three rows of equal weight become a sum row and a
// carry row. The carry row is shifted one column toward the MSB.
module wt_counter32 #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    assign s = x ^ y ^ z;
    assign c = ((x & y) | (x & z) | (y & z)) << 1;
endmodule

// File: rtl/wt_ppgen.sv
// One partial-product row per multiplier bit, placed at that bit's weight.
module wt_ppgen #(
    parameter int N = 8,
    parameter int M = 8,
    localparam int W = N + M
) (
    input  logic [N-1:0]   a,
    input  logic [M-1:0]   b,
    output logic [M*W-1:0] rows
);
    for (genvar j = 0; j < M; j++) begin : g_row
        assign rows[j*W +: W] = {{M{1'b0}}, a & {N{b[j]}}} << j;
    end
endmodule

// File: rtl/wt_csa_level.sv
// One reduction level: each group of three rows feeds a counter, and
// leftover rows pass through unchanged.
module wt_csa_level #(
    parameter int RIN = 3,
    parameter int W   = 16,
    localparam int G    = RIN / 3,
    localparam int REM  = RIN % 3,
    localparam int ROUT = 2 * G + REM
) (
    input  logic [RIN*W-1:0]  rin,
    output logic [ROUT*W-1:0] rout
);
    for (genvar g = 0; g < G; g++) begin : g_grp
        wt_counter32 #(.W(W)) u_cnt (
            .x (rin[(3*g)*W   +: W]),
            .y (rin[(3*g+1)*W +: W]),
            .z (rin[(3*g+2)*W +: W]),
            .s (rout[(2*g)*W   +: W]),
            .c (rout[(2*g+1)*W +: W])
        );
    end
    for (genvar r = 0; r < REM; r++) begin : g_pass
        assign rout[(2*G+r)*W +: W] = rin[(3*G+r)*W +: W];
    end
endmodule

// File: rtl/wt_mult.sv
module wt_mult #(
    parameter int          N         = 8,
    parameter int          M         = 8,
    parameter logic [31:0] PIPE_MASK = 32'h15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N-1:0]   a,
    input  logic [M-1:0]   b,
    output logic           out_valid,
    output logic [N+M-1:0] product
);
    import wt_pkg::*;

    localparam int W      = N + M;
    localparam int LEVELS = tree_levels(M);
    localparam int RFIN   = rows_after(M, LEVELS);

    logic [M*W-1:0] pp_rows;

    wt_ppgen #(.N(N), .M(M)) u_pp (
        .a    (a),
        .b    (b),
        .rows (pp_rows)
    );

    // Reduction levels; the valid flag rides in the MSB of each bus.
    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam int RIN  = rows_after(M, k);
        localparam int ROUT = rows_after(M, k + 1);

        logic [RIN*W:0]    lv_in;
        logic [ROUT*W-1:0] lv_sum;
        logic [ROUT*W:0]   lv_q;

        if (k == 0) begin : g_src
            assign lv_in = {in_valid, pp_rows};
        end else begin : g_src
            assign lv_in = g_lvl[k-1].lv_q;
        end

        wt_csa_level #(.RIN(RIN), .W(W)) u_csa (
            .rin  (lv_in[RIN*W-1:0]),
            .rout (lv_sum)
        );

        if (PIPE_MASK[k]) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lv_q <= '0;
                else        lv_q <= {lv_in[RIN*W], lv_sum};
            end
        end else begin : g_wire
            assign lv_q = {lv_in[RIN*W], lv_sum};
        end
    end

    // Final carry-propagate adder on the two remaining rows.
    logic [RFIN*W:0] fin_in;
    logic [W-1:0]    fin_sum;

    if (LEVELS == 0) begin : g_fin_src
        assign fin_in = {in_valid, pp_rows};
    end else begin : g_fin_src
        assign fin_in = g_lvl[LEVELS-1].lv_q;
    end

    if (RFIN == 2) begin : g_cpa
        assign fin_sum = fin_in[W-1:0] + fin_in[2*W-1:W];
    end else begin : g_cpa
        assign fin_sum = fin_in[W-1:0];
    end

    if (PIPE_MASK[LEVELS]) begin : g_out_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                product   <= '0;
            end else begin
                out_valid <= fin_in[RFIN*W];
                product   <= fin_sum;
            end
        end
    end else begin : g_out_wire
        assign out_valid = fin_in[RFIN*W];
        assign product   = fin_sum;
    end

endmodule

// File: rtl/wt_mult_chk.sv
module wt_mult_chk #(
    parameter int          N         = 8,
    parameter int          M         = 8,
    parameter logic [31:0] PIPE_MASK = 32'h15
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N-1:0]   a,
    input logic [M-1:0]   b,
    input logic           out_valid,
    input logic [N+M-1:0] product
);
    import wt_pkg::*;

    localparam int W   = N + M;
    localparam int LAT = stage_count(tree_levels(M), PIPE_MASK);

    logic           ref_v;
    logic [N-1:0]   ref_a;
    logic [M-1:0]   ref_b;
    logic [W-1:0]   ref_p;

    if (LAT == 0) begin : g_shadow
        assign ref_v = in_valid;
        assign ref_a = a;
        assign ref_b = b;
    end else begin : g_shadow
        logic         sv [LAT];
        logic [N-1:0] sa [LAT];
        logic [M-1:0] sb [LAT];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < LAT; i++) sv[i] <= 1'b0;
            end else begin
                sv[0] <= in_valid;
                for (int i = 1; i < LAT; i++) sv[i] <= sv[i-1];
            end
        end
        always_ff @(posedge clk) begin
            sa[0] <= a;
            sb[0] <= b;
            for (int i = 1; i < LAT; i++) begin
                sa[i] <= sa[i-1];
                sb[i] <= sb[i-1];
            end
        end
        assign ref_v = sv[LAT-1];
        assign ref_a = sa[LAT-1];
        assign ref_b = sb[LAT-1];
    end

    assign ref_p = W'(ref_a) * W'(ref_b);

    // R2, R4: the valid flag tracks the input flag delayed by LAT
    a_r2_valid_track: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == ref_v);

    // R1: the product matches the operands presented LAT cycles earlier
    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> product == ref_p);

    // R5: a zero operand gives zero
    a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (ref_a == '0 || ref_b == '0)) |-> product == '0);

    // R6: the product never exceeds the all-ones product
    a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> product <= W'({N{1'b1}}) * W'({M{1'b1}}));

endmodule

bind wt_mult wt_mult_chk #(.N(N), .M(M), .PIPE_MASK(PIPE_MASK)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/test_wt_mult.sv
`timescale 1ns/1ps
module test_wt_mult;
    localparam int N   = 8;
    localparam int M   = 8;
    localparam int W   = N + M;
    localparam int LAT = 3;    // R3: four levels, mask 0x15 -> three stages
    localparam int NV  = 12;

    // {a, b, expected product}
    localparam logic [31:0] VEC [NV] = '{
        32'h00_5A_0000, 32'hFF_FF_FE01, 32'hFF_01_00FF, 32'h80_80_4000,
        32'h0F_F0_0E10, 32'h12_34_03A8, 32'hAA_55_3872, 32'h7F_02_00FE,
        32'h01_01_0001, 32'h10_10_0100, 32'hC3_3C_2DB4, 32'h5A_00_0000
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] a = '0;
    logic [M-1:0] b = '0;
    logic         out_valid;
    logic [W-1:0] product;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic         hv [LAT];
    logic [W-1:0] hp [LAT];

    always #2.5 clk = ~clk;

    wt_mult #(.N(N), .M(M), .PIPE_MASK(32'h15)) i_wt_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .product   (product)
    );

    task automatic clear_hist();
        for (int i = 0; i < LAT; i++) begin
            hv[i] = 1'b0;
            hp[i] = '0;
        end
    endtask

    // Called at a negedge: check outputs, then present the next pair.
    task automatic cycle(input logic v, input logic [N-1:0] xa,
                         input logic [M-1:0] xb, input logic [W-1:0] exp_p,
                         input string tag);
        checks++;
        if (out_valid !== hv[LAT-1]) begin
            errors++;
            $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, hv[LAT-1]);
        end
        if (hv[LAT-1]) begin
            checks++;
            if (product !== hp[LAT-1]) begin
                errors++;
                $display("FAIL %s product actual %h expected %h", tag, product, hp[LAT-1]);
            end
        end
        for (int i = LAT - 1; i > 0; i--) begin
            hv[i] = hv[i-1];
            hp[i] = hp[i-1];
        end
        hv[0] = v;
        hp[0] = exp_p;
        in_valid = v;
        a = xa;
        b = xb;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_hist();
        repeat (4) @(negedge clk);
        // R4: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R4 out_valid in reset actual %0b expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R5, R6, R7: table streamed back to back, then drained
        for (int i = 0; i < NV + LAT; i++) begin
            if (i < NV) begin
                logic [31:0] e;
                string t;
                e = VEC[i];
                if (e[31:24] == 0 || e[23:16] == 0) t = "R5";
                else if (e[15:0] == 16'hFE01)       t = "R6";
                else                                t = "R1 R7";
                cycle(1'b1, e[31:24], e[23:16], e[15:0], t);
            end else begin
                cycle(1'b0, '0, '0, '0, "R2");
            end
        end

        // R2, R7: random operands with random gaps in in_valid
        for (int i = 0; i < 400; i++) begin
            logic [N-1:0] ra;
            logic [M-1:0] rb;
            logic         rv;
            ra = N'($urandom);
            rb = M'($urandom);
            rv = 1'($urandom);
            if (i % 37 == 0) ra = '1;
            if (i % 41 == 0) rb = '0;
            cycle(rv, ra, rb, W'(ra) * W'(rb), "R1 random");
        end

        // R4: reset in the middle of a valid stream
        for (int i = 0; i < 2; i++) cycle(1'b1, 8'hE7, 8'h9B, W'(8'hE7) * W'(8'h9B), "R1");
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R4 out_valid after mid-stream reset actual %0b expected 0", out_valid);
        end
        clear_hist();
        rst_n = 1'b1;
        @(negedge clk);
        // R4: nothing valid emerges until new valid pairs cross the pipe
        for (int i = 0; i < LAT + 2; i++) cycle(1'b0, 8'h33, 8'h44, '0, "R4");
        cycle(1'b1, 8'hFF, 8'hFF, 16'hFE01, "R6");
        for (int i = 0; i < LAT; i++) cycle(1'b0, '0, '0, '0, "R6");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule